// File: doc/BRIEF.md
# Model-Specific Register Access Unit

This block holds the processor's model-specific configuration registers and performs the read and write accesses made to them. Each request carries a 32-bit register index, a direction and, for a write, a 64-bit value supplied as a high and a low 32-bit word. The core also supplies its current privilege level, a real-mode flag and a paging-enable flag. Results and the fault flag are combinational in the cycle of the request. A write that passes its register's check is committed at the next rising clock edge.

Before a write is committed it is checked against rules that depend on the register. Memory-type range registers check their type bytes. The page-attribute register checks all eight of its bytes. Address-holding registers must contain canonical addresses. The extended-feature register refuses reserved bits and refuses a change to long-mode enable while paging is on. The interrupt-controller base register only accepts a write while it is globally enabled. A failed check raises `fault`, and no state changes. The effects these registers have on the rest of the core are handled elsewhere.

Top module: `msr_access_unit`

## Requirements
- R1: When `req_valid` is set, `real_mode` is 0 and `cpl` is not 0, `fault` is 1 and no register changes. In real mode, any `cpl` is allowed.
- R2: A write stores {`wr_hi`,`wr_lo`}. A non-faulting read returns bits 31:0 on `rd_lo` and bits 63:32 on `rd_hi`. Writes and faulting accesses return zero on both. After reset the page-attribute register reads 0x00070406_00070406, the interrupt-controller base reads 0xFEE00900 and all other stored registers read 0.
- R3: The range-capability register (index 0x200) reads the `CAP_VALUE` parameter. A write to it faults.
- R4: Memory type codes 0, 1, 4, 5 and 6 are valid for range registers. There are eight variable-range pairs at indices 0x210 to 0x21F: base k is at 0x210+2k and mask k is at 0x211+2k. A base write faults if bits 7:0 are not a valid type. Mask writes are not checked.
- R5: The 64K fixed register (0x230), the two 16K fixed registers (0x231, 0x232) and the default-type register (0x240) fault when bits 7:0 are not a valid type. The default-type register keeps only the low 32 bits. The eight 4K fixed registers (0x238 to 0x23F) store any value.
- R6: A write to the page-attribute register (0x250) is accepted only if all eight bytes are valid range types or 0x07.
- R7: A write to the extended-feature register (0x400) faults if any bit outside `EXT_SUPPORTED` is set.
- R8: An extended-feature write faults if `paging_on` is 1 and bit 8 of the value differs from the stored bit 8. Stored bit 10 is never altered by a write.
- R9: A write to the interrupt-controller base (0x300) stores only `wr_lo`, with the high half reading 0. The write takes effect only when stored bit 11 is 1. Otherwise it is silently dropped, without a fault.
- R10: Writes to the sysenter stack (0x101) and instruction (0x102) pointers, the long (0x401) and compatibility (0x402) syscall targets, and the FS (0x410), GS (0x411) and kernel-GS (0x412) bases fault unless bits 63:47 are all equal.
- R11: The sysenter code-segment register (0x100) and the syscall flag mask (0x403) keep only `wr_lo`. Their high half reads 0.
- R12: An index outside the map faults on read and on write when `IGNORE_BAD_IDX` is 0. When it is 1, such an access does not fault and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| wr_hi | input | 32 | Write value bits 63:32 |
| wr_lo | input | 32 | Write value bits 31:0 |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Core is in real mode |
| paging_on | input | 1 | Paging enabled |
| rd_lo | output | 32 | Read data bits 31:0 |
| rd_hi | output | 32 | Read data bits 63:32 |
| fault | output | 1 | General-protection fault for this request |

## Verification
Stored state is only visible through reads, so each write is followed by a read of the same index in the next cycle. That read exposes a wrong commit, a missed commit or a wrongly truncated value one clock after the write edge. A wrong check decision shows immediately on `fault` in the request cycle. Dropped and rejected writes are confirmed by reading back the previous value. The gated interrupt-controller base and the preserved long-mode-active bit are shown through sequences in which a first accepted write changes the gate condition for the next write.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int N_VAR     = 8;
    localparam int N_FIX4    = 8;
    localparam int SUB_W     = $clog2(2 * N_VAR);
    localparam int VA_W      = 48;

    localparam int EXT_LME_BIT = 8;
    localparam int EXT_LMA_BIT = 10;
    localparam int CTL_EN_BIT  = 11;

    localparam logic [63:0] PAT_RESET = 64'h0007_0406_0007_0406;

    localparam logic [31:0] IX_SEP_CS = 32'h0000_0100;
    localparam logic [31:0] IX_SEP_SP = 32'h0000_0101;
    localparam logic [31:0] IX_SEP_IP = 32'h0000_0102;
    localparam logic [31:0] IX_CAP    = 32'h0000_0200;
    localparam logic [31:0] IX_VAR0   = 32'h0000_0210;
    localparam logic [31:0] IX_FIX64  = 32'h0000_0230;
    localparam logic [31:0] IX_FIX16  = 32'h0000_0231;
    localparam logic [31:0] IX_FIX4   = 32'h0000_0238;
    localparam logic [31:0] IX_DEFT   = 32'h0000_0240;
    localparam logic [31:0] IX_PAT    = 32'h0000_0250;
    localparam logic [31:0] IX_CTL    = 32'h0000_0300;
    localparam logic [31:0] IX_EXT    = 32'h0000_0400;
    localparam logic [31:0] IX_LTGT   = 32'h0000_0401;
    localparam logic [31:0] IX_CTGT   = 32'h0000_0402;
    localparam logic [31:0] IX_FMASK  = 32'h0000_0403;
    localparam logic [31:0] IX_FSB    = 32'h0000_0410;
    localparam logic [31:0] IX_GSB    = 32'h0000_0411;
    localparam logic [31:0] IX_KGSB   = 32'h0000_0412;

    typedef enum logic [3:0] {
        C_NONE, C_SEP_CS, C_CAP, C_VBASE, C_VMASK, C_FIX64, C_FIX16,
        C_FIX4, C_DEFT, C_PAT, C_CTL, C_EXT, C_CANON, C_FMASK
    } reg_cls_e;

    typedef struct packed {
        reg_cls_e         cls;
        logic [SUB_W-1:0] sub;
    } reg_sel_t;

    function automatic logic range_type_ok(input logic [7:0] t);
        return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
    endfunction

    function automatic logic pat_type_ok(input logic [7:0] t);
        return (t == 8'd7) || range_type_ok(t);
    endfunction

    function automatic logic addr_canonical(input logic [63:0] v);
        logic [63:0] sext;
        sext = {{(64 - VA_W){v[VA_W-1]}}, v[VA_W-1:0]};
        return sext == v;
    endfunction

endpackage

// File: rtl/msr_decode.sv
module msr_decode
    import msr_pkg::*;
(
    input  logic [31:0] index,
    output reg_sel_t    sel
);
    localparam logic [31:0] VAR_END  = IX_VAR0 + 32'(2 * N_VAR);
    localparam logic [31:0] FIX4_END = IX_FIX4 + 32'(N_FIX4);

    logic [31:0] var_off;
    logic [31:0] fix4_off;

    always_comb begin
        var_off  = index - IX_VAR0;
        fix4_off = index - IX_FIX4;
        sel      = '{cls: C_NONE, sub: '0};
        if (index >= IX_VAR0 && index < VAR_END) begin
            sel.cls = var_off[0] ? C_VMASK : C_VBASE;
            sel.sub = var_off[SUB_W-1:0];
        end else if (index >= IX_FIX4 && index < FIX4_END) begin
            sel.cls = C_FIX4;
            sel.sub = fix4_off[SUB_W-1:0];
        end else begin
            case (index)
                IX_SEP_CS: sel.cls = C_SEP_CS;
                IX_SEP_SP: sel = '{cls: C_CANON, sub: SUB_W'(0)};
                IX_SEP_IP: sel = '{cls: C_CANON, sub: SUB_W'(1)};
                IX_LTGT:   sel = '{cls: C_CANON, sub: SUB_W'(2)};
                IX_CTGT:   sel = '{cls: C_CANON, sub: SUB_W'(3)};
                IX_FSB:    sel = '{cls: C_CANON, sub: SUB_W'(4)};
                IX_GSB:    sel = '{cls: C_CANON, sub: SUB_W'(5)};
                IX_KGSB:   sel = '{cls: C_CANON, sub: SUB_W'(6)};
                IX_CAP:    sel.cls = C_CAP;
                IX_FIX64:  sel.cls = C_FIX64;
                IX_FIX16:  sel = '{cls: C_FIX16, sub: SUB_W'(0)};
                IX_FIX16 + 32'd1: sel = '{cls: C_FIX16, sub: SUB_W'(1)};
                IX_DEFT:   sel.cls = C_DEFT;
                IX_PAT:    sel.cls = C_PAT;
                IX_CTL:    sel.cls = C_CTL;
                IX_EXT:    sel.cls = C_EXT;
                IX_FMASK:  sel.cls = C_FMASK;
                default:   sel.cls = C_NONE;
            endcase
        end
    end
endmodule

// File: rtl/msr_check.sv
module msr_check
    import msr_pkg::*;
#(
    parameter logic [63:0] EXT_SUPPORTED = 64'h0000_0000_0000_0D01
) (
    input  reg_sel_t    sel,
    input  logic [63:0] wdata,
    input  logic [63:0] ext_cur,
    input  logic        paging_on,
    output logic        chk_fault
);
    logic [7:0] pat_ok;

    generate
        for (genvar b = 0; b < 8; b++) begin : g_pat_byte
            assign pat_ok[b] = pat_type_ok(wdata[8*b +: 8]);
        end
    endgenerate

    logic ext_bad;
    assign ext_bad = (|(wdata & ~EXT_SUPPORTED)) ||
                     (paging_on && (wdata[EXT_LME_BIT] != ext_cur[EXT_LME_BIT]));

    always_comb begin
        unique case (sel.cls)
            C_CAP:                    chk_fault = 1'b1;
            C_VBASE, C_FIX64,
            C_FIX16, C_DEFT:          chk_fault = !range_type_ok(wdata[7:0]);
            C_PAT:                    chk_fault = !(&pat_ok);
            C_EXT:                    chk_fault = ext_bad;
            C_CANON:                  chk_fault = !addr_canonical(wdata);
            default:                  chk_fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/msr_store.sv
module msr_store
    import msr_pkg::*;
#(
    parameter logic [63:0] CAP_VALUE     = 64'h0000_0000_0000_0508,
    parameter logic [31:0] CTL_RESET     = 32'hFEE0_0900,
    parameter logic [63:0] EXT_SUPPORTED = 64'h0000_0000_0000_0D01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  reg_sel_t    sel,
    input  logic [63:0] wdata,
    output logic [63:0] rdata,
    output logic [63:0] ext_cur
);
    localparam logic [63:0] LMA_MASK = 64'd1 << EXT_LMA_BIT;

    logic [63:0] var_q   [2*N_VAR];
    logic [63:0] fix4_q  [N_FIX4];
    logic [63:0] canon_q [8];
    logic [63:0] fix16_q [2];
    logic [63:0] fix64_q, pat_q, ext_q;
    logic [31:0] sep_cs_q, deft_q, ctl_q, fmask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2*N_VAR; i++) var_q[i] <= '0;
            for (int i = 0; i < N_FIX4; i++)  fix4_q[i] <= '0;
            for (int i = 0; i < 8; i++)       canon_q[i] <= '0;
            fix16_q[0] <= '0;
            fix16_q[1] <= '0;
            fix64_q    <= '0;
            pat_q      <= PAT_RESET;
            ext_q      <= '0;
            sep_cs_q   <= '0;
            deft_q     <= '0;
            ctl_q      <= CTL_RESET;
            fmask_q    <= '0;
        end else if (we) begin
            case (sel.cls)
                C_SEP_CS:         sep_cs_q <= wdata[31:0];
                C_CANON:          canon_q[sel.sub[2:0]] <= wdata;
                C_VBASE, C_VMASK: var_q[sel.sub] <= wdata;
                C_FIX64:          fix64_q <= wdata;
                C_FIX16:          fix16_q[sel.sub[0]] <= wdata;
                C_FIX4:           fix4_q[sel.sub[2:0]] <= wdata;
                C_DEFT:           deft_q <= wdata[31:0];
                C_PAT:            pat_q <= wdata;
                C_CTL:            if (ctl_q[CTL_EN_BIT]) ctl_q <= wdata[31:0];
                C_EXT:            ext_q <= (wdata & EXT_SUPPORTED & ~LMA_MASK) | (ext_q & LMA_MASK);
                C_FMASK:          fmask_q <= wdata[31:0];
                default:          ;
            endcase
        end
    end

    always_comb begin
        case (sel.cls)
            C_SEP_CS:         rdata = {32'd0, sep_cs_q};
            C_CANON:          rdata = canon_q[sel.sub[2:0]];
            C_CAP:            rdata = CAP_VALUE;
            C_VBASE, C_VMASK: rdata = var_q[sel.sub];
            C_FIX64:          rdata = fix64_q;
            C_FIX16:          rdata = fix16_q[sel.sub[0]];
            C_FIX4:           rdata = fix4_q[sel.sub[2:0]];
            C_DEFT:           rdata = {32'd0, deft_q};
            C_PAT:            rdata = pat_q;
            C_CTL:            rdata = {32'd0, ctl_q};
            C_EXT:            rdata = ext_q;
            C_FMASK:          rdata = {32'd0, fmask_q};
            default:          rdata = '0;
        endcase
    end

    assign ext_cur = ext_q;

    // R8: the long-mode-active bit never moves after reset
    p_lma_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $stable(ext_q[EXT_LMA_BIT]));

    // R9: a disabled controller base cannot be rewritten
    p_ctl_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[CTL_EN_BIT] |=> $stable(ctl_q));
endmodule

// File: rtl/msr_access_unit.sv
module msr_access_unit
    import msr_pkg::*;
#(
    parameter bit          IGNORE_BAD_IDX = 1'b0,
    parameter logic [63:0] CAP_VALUE      = 64'h0000_0000_0000_0508,
    parameter logic [31:0] CTL_RESET      = 32'hFEE0_0900,
    parameter logic [63:0] EXT_SUPPORTED  = 64'h0000_0000_0000_0D01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_index,
    input  logic [31:0] wr_hi,
    input  logic [31:0] wr_lo,
    input  logic [1:0]  cpl,
    input  logic        real_mode,
    input  logic        paging_on,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi,
    output logic        fault
);
    reg_sel_t    sel;
    logic [63:0] wdata, rdata, ext_cur;
    logic        chk_fault, priv_bad, idx_bad, commit;

    assign wdata = {wr_hi, wr_lo};

    msr_decode u_dec (.index(req_index), .sel(sel));

    msr_check #(.EXT_SUPPORTED(EXT_SUPPORTED)) u_chk (
        .sel(sel), .wdata(wdata), .ext_cur(ext_cur),
        .paging_on(paging_on), .chk_fault(chk_fault)
    );

    assign priv_bad = !real_mode && (cpl != 2'd0);
    assign idx_bad  = (sel.cls == C_NONE) && !IGNORE_BAD_IDX;
    assign fault    = req_valid && (priv_bad || idx_bad || (req_write && chk_fault));
    assign commit   = req_valid && req_write && !fault;

    msr_store #(
        .CAP_VALUE(CAP_VALUE), .CTL_RESET(CTL_RESET), .EXT_SUPPORTED(EXT_SUPPORTED)
    ) u_st (
        .clk(clk), .rst(rst), .we(commit), .sel(sel), .wdata(wdata),
        .rdata(rdata), .ext_cur(ext_cur)
    );

    always_comb begin
        if (req_valid && !req_write && !fault) begin
            rd_lo = rdata[31:0];
            rd_hi = rdata[63:32];
        end else begin
            rd_lo = '0;
            rd_hi = '0;
        end
    end

    // R1: user level outside real mode always faults
    p_priv_fault_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !real_mode && cpl != 2'd0) |-> fault);

    // R3: the capability register cannot be written
    p_cap_ro_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_index == IX_CAP) |-> fault);

    generate
        if (!IGNORE_BAD_IDX) begin : g_strict
            // R12: unmapped index faults in strict mode
            p_unknown_r12: assert property (@(posedge clk) disable iff (rst)
                (req_valid && u_dec.sel.cls == C_NONE) |-> fault);
        end
    endgenerate
endmodule

// File: tb/sim_msr_access_unit.sv
module sim_msr_access_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, real_mode = 1'b0, paging_on = 1'b0;
    logic [31:0] req_index = '0, wr_hi = '0, wr_lo = '0;
    logic [1:0]  cpl = '0;
    logic [31:0] rd_lo, rd_hi, rd_lo1, rd_hi1;
    logic        fault, fault1;

    always #2 clk = ~clk;

    msr_access_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .wr_hi(wr_hi), .wr_lo(wr_lo), .cpl(cpl),
        .real_mode(real_mode), .paging_on(paging_on),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .fault(fault)
    );

    msr_access_unit #(.IGNORE_BAD_IDX(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .wr_hi(wr_hi), .wr_lo(wr_lo), .cpl(cpl),
        .real_mode(real_mode), .paging_on(paging_on),
        .rd_lo(rd_lo1), .rd_hi(rd_hi1), .fault(fault1)
    );

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        logic        f;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    task automatic op(input logic wr, input logic [31:0] idx, input logic [63:0] val,
                      input logic [1:0] pl, input logic rm,
                      input logic [31:0] elo, input logic [31:0] ehi, input logic ef,
                      input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_index = idx;
        wr_hi = val[63:32]; wr_lo = val[31:0]; cpl = pl; real_mode = rm;
        e.lo = elo; e.hi = ehi; e.f = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [31:0] idx, input logic [63:0] val, input logic ef,
                      input string tag);
        op(1'b1, idx, val, 2'd0, 1'b0, 32'd0, 32'd0, ef, tag);
    endtask

    task automatic rd(input logic [31:0] idx, input logic [63:0] ev, input string tag);
        op(1'b0, idx, 64'd0, 2'd0, 1'b0, ev[31:0], ev[63:32], 1'b0, tag);
    endtask

    always @(negedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (rd_lo !== e.lo || rd_hi !== e.hi || fault !== e.f) begin
                errors++;
                $display("FAIL %s: got lo=%h hi=%h fault=%b, expected lo=%h hi=%h fault=%b",
                         e.tag, rd_lo, rd_hi, fault, e.lo, e.hi, e.f);
            end
        end
    end

    task automatic check_ign(input string tag);
        #1;
        checks++;
        if (rd_lo1 !== 32'd0 || rd_hi1 !== 32'd0 || fault1 !== 1'b0) begin
            errors++;
            $display("FAIL %s: got lo=%h hi=%h fault=%b, expected lo=0 hi=0 fault=0",
                     tag, rd_lo1, rd_hi1, fault1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2 reset values and split read
        rd(32'h250, 64'h0007_0406_0007_0406, "R2 pat reset");
        rd(32'h300, 64'h0000_0000_FEE0_0900, "R2 ctl reset");
        // R1 privilege
        op(1'b1, 32'h250, 64'd0, 2'd3, 1'b0, 0, 0, 1'b1, "R1 user write faults");
        op(1'b0, 32'h250, 64'd0, 2'd3, 1'b0, 0, 0, 1'b1, "R1 user read faults");
        rd(32'h250, 64'h0007_0406_0007_0406, "R1 pat unchanged");
        op(1'b0, 32'h250, 64'd0, 2'd3, 1'b1, 32'h0007_0406, 32'h0007_0406, 1'b0, "R1 real mode ok");
        // R4 variable ranges
        wr(32'h210, 64'h0000_000F_FFFF_F006, 1'b0, "R4 base0 wb");
        rd(32'h210, 64'h0000_000F_FFFF_F006, "R4 base0 read");
        wr(32'h212, 64'h0000_0000_0000_0007, 1'b1, "R4 base1 bad type");
        rd(32'h212, 64'd0, "R4 base1 unchanged");
        wr(32'h21F, 64'h0000_0003_0000_0807, 1'b0, "R4 mask7 unchecked");
        rd(32'h21F, 64'h0000_0003_0000_0807, "R4 mask7 read");
        // R5 fixed ranges and default type
        wr(32'h230, 64'h0000_0000_0000_0002, 1'b1, "R5 fix64 bad");
        wr(32'h230, 64'h0606_0606_0606_0605, 1'b0, "R5 fix64 ok");
        rd(32'h230, 64'h0606_0606_0606_0605, "R5 fix64 read");
        wr(32'h232, 64'h0000_0000_0000_0003, 1'b1, "R5 fix16b bad");
        wr(32'h23F, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5 fix4 unchecked");
        rd(32'h23F, 64'hFFFF_FFFF_FFFF_FFFF, "R5 fix4 read");
        wr(32'h240, 64'h0000_0000_0000_0C07, 1'b1, "R5 deftype bad");
        wr(32'h240, 64'h0000_0055_0000_0C06, 1'b0, "R5 deftype ok");
        rd(32'h240, 64'h0000_0000_0000_0C06, "R5 deftype low half");
        // R6 page attributes
        wr(32'h250, 64'h0706_0504_0100_0706, 1'b0, "R6 pat valid incl 07");
        rd(32'h250, 64'h0706_0504_0100_0706, "R6 pat read");
        wr(32'h250, 64'h0000_0200_0000_0000, 1'b1, "R6 pat byte5 bad");
        rd(32'h250, 64'h0706_0504_0100_0706, "R6 pat unchanged");
        // R3 capability
        rd(32'h200, 64'h0000_0000_0000_0508, "R3 cap read");
        wr(32'h200, 64'd0, 1'b1, "R3 cap write faults");
        // R7 / R8 extended features
        wr(32'h400, 64'h0000_0000_0000_0002, 1'b1, "R7 reserved low bit");
        wr(32'h400, 64'h0000_0001_0000_0000, 1'b1, "R7 reserved high bit");
        paging_on = 1'b1;
        wr(32'h400, 64'h0000_0000_0000_0100, 1'b1, "R8 lme set with paging");
        @(negedge clk) paging_on = 1'b0;
        wr(32'h400, 64'h0000_0000_0000_0501, 1'b0, "R8 lme set no paging");
        rd(32'h400, 64'h0000_0000_0000_0101, "R8 lma kept clear");
        @(negedge clk) paging_on = 1'b1;
        wr(32'h400, 64'h0000_0000_0000_0901, 1'b0, "R8 lme same with paging");
        rd(32'h400, 64'h0000_0000_0000_0901, "R8 read");
        wr(32'h400, 64'h0000_0000_0000_0801, 1'b1, "R8 lme clear with paging");
        rd(32'h400, 64'h0000_0000_0000_0901, "R8 unchanged");
        @(negedge clk) paging_on = 1'b0;
        // R9 controller base
        wr(32'h300, 64'h0000_000F_FEC0_0800, 1'b0, "R9 enabled write");
        rd(32'h300, 64'h0000_0000_FEC0_0800, "R9 low half only");
        wr(32'h300, 64'h0000_0000_0000_0100, 1'b0, "R9 disable write");
        rd(32'h300, 64'h0000_0000_0000_0100, "R9 disabled value");
        wr(32'h300, 64'h0000_0000_1234_5900, 1'b0, "R9 gated write no fault");
        rd(32'h300, 64'h0000_0000_0000_0100, "R9 gated write dropped");
        // R10 canonical addresses
        wr(32'h401, 64'h0000_7FFF_FFFF_F000, 1'b0, "R10 ltgt top positive");
        rd(32'h401, 64'h0000_7FFF_FFFF_F000, "R10 ltgt read");
        wr(32'h401, 64'h0000_8000_0000_0000, 1'b1, "R10 ltgt noncanonical");
        rd(32'h401, 64'h0000_7FFF_FFFF_F000, "R10 ltgt unchanged");
        wr(32'h410, 64'hFFFF_8000_0000_1000, 1'b0, "R10 fs negative");
        rd(32'h410, 64'hFFFF_8000_0000_1000, "R10 fs read");
        wr(32'h412, 64'h0001_0000_0000_0000, 1'b1, "R10 kgs noncanonical");
        wr(32'h102, 64'hFFFF_0000_0000_0000, 1'b1, "R10 sysenter ip noncanonical");
        wr(32'h101, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, "R10 sysenter sp ok");
        rd(32'h101, 64'hFFFF_FFFF_FFFF_FFF0, "R10 sysenter sp read");
        // R11 32-bit registers
        wr(32'h100, 64'h0000_AAAA_0000_1234, 1'b0, "R11 sep cs write");
        rd(32'h100, 64'h0000_0000_0000_1234, "R11 sep cs low only");
        wr(32'h403, 64'h0000_0001_0000_4700, 1'b0, "R11 fmask write");
        rd(32'h403, 64'h0000_0000_0000_4700, "R11 fmask low only");
        // R12 unmapped index
        op(1'b0, 32'h999, 64'd0, 2'd0, 1'b0, 0, 0, 1'b1, "R12 strict read");
        check_ign("R12 ignore read");
        op(1'b1, 32'h999, 64'h1234, 2'd0, 1'b0, 0, 0, 1'b1, "R12 strict write");
        check_ign("R12 ignore write");

        @(negedge clk) req_valid = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule